// File: doc/BRIEF.md
# Two-stage compare-value watchdog timer

This block is a memory-mapped watchdog that escalates in two steps. It watches a free-running 64-bit system counter, which arrives as an input, and compares it against a 64-bit compare value that it holds itself. The first time the counter reaches the compare value while the watchdog is enabled, the block raises a first-stage interrupt. At the same moment hardware moves the compare value forward to the current counter plus a 32-bit offset. If software does not refresh the watchdog before the counter reaches that new value, the block raises a second-stage reset request.

Software reaches the block through a simple 32-bit register bus with two frames. The refresh frame holds one refresh register. The control frame holds the enable and status word, the offset, and the two halves of the compare value. Writing the refresh register, the offset or the control word counts as a refresh. Software may also write the compare value directly to set an absolute deadline.

The bus has no back-pressure. A request is accepted in the cycle that `bus_req` is high. Read data comes back, flagged by `bus_rvalid`, exactly one cycle after a read request. There is no ready signal and no stall.

Top module: `twostage_wdog`

## Requirements
- R1: After reset, enable, first-stage bit, second-stage bit, offset and compare value are all zero, and both outputs are low.
- R2: When enabled, with the first-stage bit clear and with no refresh or compare write in that cycle, a counter value greater than or equal to the compare value (unsigned) sets the first-stage bit. In the same cycle the compare value is reloaded to the counter plus the offset. `irq_stage1` goes high after that clock edge.
- R3: When enabled, with the first-stage bit already set and with no refresh or compare write in that cycle, a counter value greater than or equal to the compare value sets the second-stage bit. `rst_stage2` goes high after that edge, and both bits then stay set until a refresh.
- R4: A write of any data to address 0x000 in the refresh frame (`bus_ctrl_frame`=0) is a refresh. It sets the compare value to the current counter plus the offset and clears both stage bits.
- R5: A write to the offset register (control frame 0x008) stores the data and is a refresh. The reload uses the newly written offset.
- R6: A write to the control word (control frame 0x000) sets enable from data bit 0, ignores data bits 2:1, and is a refresh.
- R7: Writes to control frame 0x010 and 0x014 replace the low and the high half of the compare value and are not a refresh. If the result is at or below the counter while the block is enabled, the next stage fires on the following cycle.
- R8: While enable is 0, neither stage bit is ever set by the compare.
- R9: Reads return the following. The control word at 0x000 reads as {29'b0, second-stage, first-stage, enable}. The offset reads at 0x008. The compare value reads as live low and high halves at 0x010 and 0x014. The refresh register reads as 0. In both frames, 0xFCC reads as 32'h0000_1A01 and 0xFD0 reads as 32'h0000_0D25. Every other offset reads as 0, and writes to it change nothing.
- R10: `bus_rvalid` is high exactly in the cycle after a read request. The read data reflects the register state before the clock edge that accepted the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_cnt | input | 64 | Free-running system counter |
| bus_req | input | 1 | Register access request, accepted the same cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_ctrl_frame | input | 1 | 1 = control frame, 0 = refresh frame |
| bus_addr | input | 12 | Byte offset within the frame |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| irq_stage1 | output | 1 | First-stage interrupt level |
| rst_stage2 | output | 1 | Second-stage reset request level |

## Verification
A wrong compare value or a wrong stage bit reaches the ports within one cycle of the event that should have moved it. It shows as an interrupt or reset level that rises too early, too late or never. It also shows in the compare halves and the control word the next time they are read. A wrong reload offset only shows later: the second stage then fires at the wrong counter value. For that reason the bench follows every stage transition with readbacks and runs the counter across a 32-bit carry.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned REG_AW = 12;
  localparam logic [REG_AW-1:0] OFS_CTRL   = 12'h000;
  localparam logic [REG_AW-1:0] OFS_OFFSET = 12'h008;
  localparam logic [REG_AW-1:0] OFS_CMP_LO = 12'h010;
  localparam logic [REG_AW-1:0] OFS_CMP_HI = 12'h014;
  localparam logic [REG_AW-1:0] OFS_IFID   = 12'hFCC;
  localparam logic [REG_AW-1:0] OFS_ID     = 12'hFD0;
  localparam logic [REG_AW-1:0] OFS_KICK   = 12'h000;

  typedef struct packed {
    logic       kick;
    logic       ctrl;
    logic       offset;
    logic [1:0] cmp;
  } wr_strobe_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 12,
  parameter logic [31:0] IFID_VAL = 32'h0000_1A01,
  parameter logic [31:0] ID_VAL   = 32'h0000_0D25,
  localparam int unsigned CNT_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic              bus_ctrl_frame,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              en_q,
  input  logic              ws0_q,
  input  logic              ws1_q,
  input  logic [DATA_W-1:0] ofs_q,
  input  logic [CNT_W-1:0]  cmp_q,
  output wr_strobe_t        wstb,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid
);
  logic wr, rd;
  logic [DATA_W-1:0] rd_mux;

  assign wr = bus_req && bus_we;
  assign rd = bus_req && !bus_we;

  always_comb begin
    wstb        = '0;
    wstb.kick   = wr && !bus_ctrl_frame && (bus_addr == ADDR_W'(OFS_KICK));
    wstb.ctrl   = wr &&  bus_ctrl_frame && (bus_addr == ADDR_W'(OFS_CTRL));
    wstb.offset = wr &&  bus_ctrl_frame && (bus_addr == ADDR_W'(OFS_OFFSET));
    wstb.cmp[0] = wr &&  bus_ctrl_frame && (bus_addr == ADDR_W'(OFS_CMP_LO));
    wstb.cmp[1] = wr &&  bus_ctrl_frame && (bus_addr == ADDR_W'(OFS_CMP_HI));
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(OFS_IFID)) begin
      rd_mux = DATA_W'(IFID_VAL);
    end else if (bus_addr == ADDR_W'(OFS_ID)) begin
      rd_mux = DATA_W'(ID_VAL);
    end else if (bus_ctrl_frame) begin
      case (bus_addr)
        ADDR_W'(OFS_CTRL):   rd_mux = DATA_W'({ws1_q, ws0_q, en_q});
        ADDR_W'(OFS_OFFSET): rd_mux = ofs_q;
        ADDR_W'(OFS_CMP_LO): rd_mux = cmp_q[DATA_W-1:0];
        ADDR_W'(OFS_CMP_HI): rd_mux = cmp_q[CNT_W-1:DATA_W];
        default:             rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd;
      if (rd) bus_rdata <= rd_mux;
    end
  end

  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we) |=> bus_rvalid); // R10
  AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && !bus_we) |=> !bus_rvalid); // R10
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  sys_cnt,
  input  logic [DATA_W-1:0] wdata,
  input  wr_strobe_t        wstb,
  output logic              en_q,
  output logic              ws0_q,
  output logic              ws1_q,
  output logic [DATA_W-1:0] ofs_q,
  output logic [CNT_W-1:0]  cmp_q
);
  logic              refresh;
  logic              any_cmp_wr;
  logic              expired;
  logic [DATA_W-1:0] ofs_nxt;
  logic [CNT_W-1:0]  reload_val;
  logic [CNT_W-1:0]  cmp_merge;

  assign refresh    = wstb.kick || wstb.ctrl || wstb.offset;
  assign any_cmp_wr = |wstb.cmp;
  assign ofs_nxt    = wstb.offset ? wdata : ofs_q;
  assign reload_val = sys_cnt + CNT_W'(ofs_nxt);
  assign expired    = en_q && (sys_cnt >= cmp_q) && !refresh && !any_cmp_wr;

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign cmp_merge[h*DATA_W +: DATA_W] =
      wstb.cmp[h] ? wdata : cmp_q[h*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      ws0_q <= 1'b0;
      ws1_q <= 1'b0;
      ofs_q <= '0;
      cmp_q <= '0;
    end else begin
      ofs_q <= ofs_nxt;
      if (wstb.ctrl) en_q <= wdata[0];
      if (refresh) begin
        cmp_q <= reload_val;
        ws0_q <= 1'b0;
        ws1_q <= 1'b0;
      end else if (any_cmp_wr) begin
        cmp_q <= cmp_merge;
      end else if (expired) begin
        if (!ws0_q) begin
          ws0_q <= 1'b1;
          cmp_q <= reload_val;
        end else begin
          ws1_q <= 1'b1;
        end
      end
    end
  end

  AST_STAGE2_NEEDS_STAGE1: assert property (@(posedge clk) disable iff (!rst_n)
    ws1_q |-> ws0_q); // R3
  AST_NO_FIRE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !$rose(ws0_q) && !$rose(ws1_q)); // R8
  AST_STAGE1_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ws0_q) |-> cmp_q == $past(sys_cnt) + CNT_W'($past(ofs_q))); // R2
  AST_REFRESH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |=> !ws0_q && !ws1_q); // R4
endmodule

// File: rtl/twostage_wdog.sv
module twostage_wdog
  import wdog_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 12,
  parameter logic [31:0] IFID_VAL = 32'h0000_1A01,
  parameter logic [31:0] ID_VAL   = 32'h0000_0D25,
  localparam int unsigned CNT_W   = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  sys_cnt,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic              bus_ctrl_frame,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              irq_stage1,
  output logic              rst_stage2
);
  wr_strobe_t        wstb;
  logic              en_q, ws0_q, ws1_q;
  logic [DATA_W-1:0] ofs_q;
  logic [CNT_W-1:0]  cmp_q;

  wdog_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IFID_VAL(IFID_VAL), .ID_VAL(ID_VAL)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_ctrl_frame(bus_ctrl_frame), .bus_addr(bus_addr),
    .en_q(en_q), .ws0_q(ws0_q), .ws1_q(ws1_q), .ofs_q(ofs_q), .cmp_q(cmp_q),
    .wstb(wstb), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  wdog_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n), .sys_cnt(sys_cnt), .wdata(bus_wdata),
    .wstb(wstb), .en_q(en_q), .ws0_q(ws0_q), .ws1_q(ws1_q),
    .ofs_q(ofs_q), .cmp_q(cmp_q)
  );

  assign irq_stage1 = ws0_q;
  assign rst_stage2 = ws1_q;
endmodule

// File: tb/twostage_wdog_tb.sv
module twostage_wdog_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] sys_cnt = '0;
  logic        bus_req = 1'b0, bus_we = 1'b0, bus_ctrl_frame = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, irq_stage1, rst_stage2;

  int checks = 0, errors = 0;
  bit m_en, m_ws0, m_ws1;
  logic [31:0] m_ofs;
  logic [63:0] m_cmp;

  always #4 clk = ~clk;

  twostage_wdog u_dut (
    .clk(clk), .rst_n(rst_n), .sys_cnt(sys_cnt), .bus_req(bus_req),
    .bus_we(bus_we), .bus_ctrl_frame(bus_ctrl_frame), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .irq_stage1(irq_stage1), .rst_stage2(rst_stage2)
  );

  function automatic logic [31:0] exp_read(bit cf, logic [11:0] a);
    if (a == 12'hFCC) return 32'h0000_1A01;
    if (a == 12'hFD0) return 32'h0000_0D25;
    if (!cf) return 32'h0;
    case (a)
      12'h000: return {29'h0, m_ws1, m_ws0, m_en};
      12'h008: return m_ofs;
      12'h010: return m_cmp[31:0];
      12'h014: return m_cmp[63:32];
      default: return 32'h0;
    endcase
  endfunction

  function automatic void model_step(bit req, bit we, bit cf, logic [11:0] a,
                                     logic [31:0] d, logic [63:0] cnt);
    bit w = req && we;
    bit kick = w && !cf && a == 12'h000;
    bit ctl  = w && cf && a == 12'h000;
    bit ofw  = w && cf && a == 12'h008;
    bit clo  = w && cf && a == 12'h010;
    bit chi  = w && cf && a == 12'h014;
    if (ofw) m_ofs = d;
    if (ctl) m_en = d[0];
    if (kick || ctl || ofw) begin
      m_cmp = cnt + {32'h0, m_ofs};
      m_ws0 = 0; m_ws1 = 0;
    end else if (clo || chi) begin
      if (clo) m_cmp[31:0] = d;
      if (chi) m_cmp[63:32] = d;
    end else if (m_en && cnt >= m_cmp) begin
      if (!m_ws0) begin m_ws0 = 1; m_cmp = cnt + {32'h0, m_ofs}; end
      else m_ws1 = 1;
    end
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(bit req, bit we, bit cf, logic [11:0] a, logic [31:0] d,
                     logic [63:0] cnt, string tag);
    logic [31:0] er;
    bus_req = req; bus_we = we; bus_ctrl_frame = cf; bus_addr = a;
    bus_wdata = d; sys_cnt = cnt;
    @(posedge clk);
    er = exp_read(cf, a);
    model_step(req, we, cf, a, d, cnt);
    @(negedge clk);
    bus_req = 0;
    check({tag, " R10 rvalid"}, 64'(bus_rvalid), 64'(req && !we));
    if (req && !we) check({tag, " rdata"}, 64'(bus_rdata), 64'(er));
    check({tag, " irq"}, 64'(irq_stage1), 64'(m_ws0));
    check({tag, " rst"}, 64'(rst_stage2), 64'(m_ws1));
  endtask

  task automatic rd(bit cf, logic [11:0] a, logic [63:0] cnt, string tag);
    cyc(1, 0, cf, a, 0, cnt, tag);
  endtask
  task automatic wr(bit cf, logic [11:0] a, logic [31:0] d, logic [63:0] cnt,
                    string tag);
    cyc(1, 1, cf, a, d, cnt, tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] cnt;
    m_en = 0; m_ws0 = 0; m_ws1 = 0; m_ofs = 0; m_cmp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(1, 12'h000, 0, "R1 ctrl");
    rd(1, 12'h010, 0, "R1 cmp lo");
    rd(1, 12'h014, 0, "R1 cmp hi");
    rd(1, 12'h008, 0, "R1 offset");
    // R5 offset write reloads with new offset
    wr(1, 12'h008, 10, 100, "R5 offset write");
    rd(1, 12'h010, 101, "R5 cmp lo=110");
    check("R5 cmp value", 64'(m_cmp), 64'd110);
    // R6 control write: enable, bits 2:1 ignored, refresh
    wr(1, 12'h000, 32'h7, 105, "R6 ctrl write");
    rd(1, 12'h000, 106, "R6 status=1");
    rd(1, 12'h010, 107, "R6 cmp lo=115");
    // R2 first stage
    cyc(0, 0, 0, 0, 0, 114, "R2 before deadline");
    cyc(0, 0, 0, 0, 0, 115, "R2 first stage");
    check("R2 irq high", 64'(irq_stage1), 64'd1);
    rd(1, 12'h010, 116, "R2 reload cmp=125");
    // R3 second stage
    cyc(0, 0, 0, 0, 0, 124, "R3 before deadline");
    cyc(0, 0, 0, 0, 0, 125, "R3 second stage");
    check("R3 rst high", 64'(rst_stage2), 64'd1);
    rd(1, 12'h000, 126, "R3 status=7");
    cyc(0, 0, 0, 0, 0, 200, "R3 holds");
    // R4 refresh frame kick
    wr(0, 12'h000, 32'hDEAD_BEEF, 130, "R4 kick");
    check("R4 ws cleared", 64'({rst_stage2, irq_stage1}), 64'd0);
    rd(1, 12'h010, 131, "R4 cmp=140");
    // R7 direct compare write below counter fires next cycle
    wr(1, 12'h010, 50, 132, "R7 cmp lo write");
    check("R7 no fire same cycle", 64'(irq_stage1), 64'd0);
    cyc(0, 0, 0, 0, 0, 133, "R7 immediate fire");
    check("R7 irq high", 64'(irq_stage1), 64'd1);
    wr(1, 12'h014, 32'h5, 134, "R7 cmp hi write");
    rd(1, 12'h014, 135, "R7 cmp hi readback");
    // R8 disabled never fires
    wr(1, 12'h000, 32'h0, 140, "R8 disable");
    wr(1, 12'h010, 0, 141, "R8 cmp lo 0");
    wr(1, 12'h014, 0, 142, "R8 cmp hi 0");
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 0, 64'(1000 + i), "R8 idle");
    check("R8 no fire", 64'({rst_stage2, irq_stage1}), 64'd0);
    // R9 read map, unmapped writes ignored
    rd(1, 12'hFCC, 1010, "R9 ctrl ifid");
    rd(0, 12'hFCC, 1011, "R9 kick ifid");
    rd(1, 12'hFD0, 1012, "R9 ctrl id");
    rd(0, 12'hFD0, 1013, "R9 kick id");
    rd(0, 12'h000, 1014, "R9 kick reads 0");
    wr(1, 12'h004, 32'hFFFF_FFFF, 1015, "R9 unmapped write");
    rd(1, 12'h004, 1016, "R9 unmapped read 0");
    wr(0, 12'h008, 32'hFFFF_FFFF, 1017, "R9 refresh frame unmapped");
    rd(1, 12'h008, 1018, "R9 offset unchanged");
    rd(1, 12'h010, 1019, "R9 cmp unchanged");
    // random mix across a 32-bit carry
    void'($urandom(32'h5EED_0001));
    cnt = 64'h0000_0001_FFFF_FF00;
    wr(1, 12'h000, 1, cnt, "R6 enable random");
    for (int i = 0; i < 4000; i++) begin
      int k = $urandom_range(0, 19);
      cnt = cnt + 64'($urandom_range(0, 3));
      case (k)
        0: wr(0, 12'h000, $urandom, cnt, "R4 rnd kick");
        1: wr(1, 12'h000, $urandom_range(0, 7) | 32'h1, cnt, "R6 rnd ctrl");
        2: wr(1, 12'h008, $urandom_range(0, 40), cnt, "R5 rnd offset");
        3: wr(1, 12'h010, cnt[31:0] + $urandom_range(0, 30), cnt, "R7 rnd lo");
        4: wr(1, 12'h014, cnt[63:32], cnt, "R7 rnd hi");
        5: rd(1, 12'h000, cnt, "R9 rnd ctrl");
        6: rd(1, 12'h010, cnt, "R9 rnd lo");
        7: rd(1, 12'h014, cnt, "R9 rnd hi");
        8: rd($urandom_range(0, 1), 12'($urandom_range(0, 31) * 4), cnt, "R9 rnd any");
        9: if ($urandom_range(0, 9) == 0) wr(1, 12'h000, 0, cnt, "R8 rnd off");
           else cyc(0, 0, 0, 0, 0, cnt, "R3 rnd idle");
        default: cyc(0, 0, 0, 0, 0, cnt, "R2 rnd idle");
      endcase
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule